// File: doc/BRIEF.md
# Masked Color-Key Video Overlay Mixer

This block picks, one pixel at a time, whether the display shows the graphics plane or the video plane. Each pixel slot brings a 24-bit graphics pixel, a 24-bit video pixel and a flag that says whether the slot lies inside the overlay window. A programmable key, a bit mask and a one-bit keying mode decide the choice. Outside the window the graphics pixel always wins.

The keying mode has two values. In graphics-match mode (`KEY_ON_GFX_MATCH`, mode 0) the masked graphics pixel is tested against the masked key, and a match shows video. In video-mismatch mode (`KEY_ON_VID_MISMATCH`, mode 1) the masked video pixel is tested, and video is shown only when it differs from the key. Clearing mask bits widens the key into a range of colors. The mixer has a single pipeline stage. A configuration write made in a given cycle applies only to pixels that arrive in later cycles.

Top module: `ckmix_overlay_mixer`

## Requirements
- R1: After reset the key, the mask and the mode are all zero. `key_rdata`, `mask_rdata`, `mode_rdata` and `out_valid` read 0.
- R2: A cycle with `key_we` high stores `cfg_wdata[23:0]` as the key. `key_rdata` then returns it in bits 23:0, with bits 31:24 reading zero.
- R3: A cycle with `mask_we` high stores `cfg_wdata[23:0]` as the mask. `mask_rdata` then returns it in bits 23:0, with bits 31:24 reading zero.
- R4: With mode 0 and the window flag set, the output is the video pixel when (graphics AND mask) equals (key AND mask). Otherwise the output is the graphics pixel.
- R5: With mode 1 and the window flag set, the output is the video pixel when (video AND mask) differs from (key AND mask). Otherwise the output is the graphics pixel.
- R6: With the window flag clear, the output is the graphics pixel in both modes.
- R7: A mask bit of 0 removes that bit position from the compare on both sides. With the reset mask of all zeros, mode 0 selects video everywhere inside the window and mode 1 selects graphics.
- R8: `out_pix`, `out_valid` and `out_window` appear exactly one clock after the pixel inputs they belong to.
- R9: A write to the key, mask or mode (`cfg_wdata[0]` sets the mode) changes selection starting with the pixel of the next clock. A pixel presented in the same cycle as the write uses the old setting.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Pixel slot valid |
| in_window | input | 1 | Slot lies inside the overlay window |
| gfx_pix | input | 24 | Graphics pixel |
| vid_pix | input | 24 | Video pixel |
| key_we | input | 1 | Write strobe for the key |
| mask_we | input | 1 | Write strobe for the mask |
| mode_we | input | 1 | Write strobe for the mode |
| cfg_wdata | input | 24 | Write data, shared by all three settings |
| key_rdata | output | 32 | Key readback, bits 31:24 zero |
| mask_rdata | output | 32 | Mask readback, bits 31:24 zero |
| mode_rdata | output | 1 | Current keying mode |
| out_valid | output | 1 | Output pixel valid |
| out_window | output | 1 | Delayed window flag |
| out_pix | output | 24 | Selected pixel |

## Verification
The only state is the three setting registers and the single output stage. If any of it is wrong, the fault shows up on the first valid pixel after the bad write: `out_pix` carries the wrong source one clock after that pixel goes in. A stale or early setting shows up in the cycle the write coincides with a pixel. A bad stage register shows up as `out_valid` or `out_window` slipping against `out_pix` in that same clock. The test vectors use graphics and video pixels that always differ, so every wrong selection can be seen at the output.

// File: rtl/ckmix_pkg.sv
package ckmix_pkg;
    localparam int PIX_W = 24;
    localparam int REG_W = 32;

    typedef enum logic {
        KEY_ON_GFX_MATCH    = 1'b0,
        KEY_ON_VID_MISMATCH = 1'b1
    } key_mode_e;
endpackage

// File: rtl/ckmix_regs.sv
module ckmix_regs
    import ckmix_pkg::*;
#(
    parameter int PW = PIX_W,
    parameter int RW = REG_W
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          key_we,
    input  logic          mask_we,
    input  logic          mode_we,
    input  logic [PW-1:0] cfg_wdata,
    output logic [PW-1:0] key_q,
    output logic [PW-1:0] mask_q,
    output key_mode_e     mode_q,
    output logic [RW-1:0] key_rdata,
    output logic [RW-1:0] mask_rdata
);
    localparam int PAD_W = RW - PW;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            key_q  <= '0;
            mask_q <= '0;
            mode_q <= KEY_ON_GFX_MATCH;
        end else begin
            if (key_we)  key_q  <= cfg_wdata;
            if (mask_we) mask_q <= cfg_wdata;
            if (mode_we) mode_q <= key_mode_e'(cfg_wdata[0]);
        end
    end

    always_comb begin
        key_rdata  = {{PAD_W{1'b0}}, key_q};
        mask_rdata = {{PAD_W{1'b0}}, mask_q};
    end

    AST_KEY_WRITE:  assert property (@(posedge clk) disable iff (!rst_n)
        key_we |=> key_q == $past(cfg_wdata)); // R2
    AST_MASK_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        mask_we |=> mask_q == $past(cfg_wdata)); // R3
    AST_MODE_HOLD:  assert property (@(posedge clk) disable iff (!rst_n)
        !mode_we |=> $stable(mode_q)); // R9
endmodule

// File: rtl/ckmix_match.sv
module ckmix_match #(
    parameter int W = 24
) (
    input  logic [W-1:0] sample,
    input  logic [W-1:0] key,
    input  logic [W-1:0] mask,
    output logic         hit
);
    always_comb begin
        hit = ((sample & mask) == (key & mask));
    end
endmodule

// File: rtl/ckmix_overlay_mixer.sv
module ckmix_overlay_mixer
    import ckmix_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             in_valid,
    input  logic             in_window,
    input  logic [PIX_W-1:0] gfx_pix,
    input  logic [PIX_W-1:0] vid_pix,
    input  logic             key_we,
    input  logic             mask_we,
    input  logic             mode_we,
    input  logic [PIX_W-1:0] cfg_wdata,
    output logic [REG_W-1:0] key_rdata,
    output logic [REG_W-1:0] mask_rdata,
    output logic             mode_rdata,
    output logic             out_valid,
    output logic             out_window,
    output logic [PIX_W-1:0] out_pix
);
    logic [PIX_W-1:0] key_q;
    logic [PIX_W-1:0] mask_q;
    key_mode_e        mode_q;
    logic             gfx_hit;
    logic             vid_hit;
    logic             take_vid;
    logic [PIX_W-1:0] sel_pix;

    ckmix_regs #(.PW(PIX_W), .RW(REG_W)) u_regs (
        .clk        (clk),
        .rst_n      (rst_n),
        .key_we     (key_we),
        .mask_we    (mask_we),
        .mode_we    (mode_we),
        .cfg_wdata  (cfg_wdata),
        .key_q      (key_q),
        .mask_q     (mask_q),
        .mode_q     (mode_q),
        .key_rdata  (key_rdata),
        .mask_rdata (mask_rdata)
    );

    ckmix_match #(.W(PIX_W)) u_gfx_match (
        .sample (gfx_pix),
        .key    (key_q),
        .mask   (mask_q),
        .hit    (gfx_hit)
    );

    ckmix_match #(.W(PIX_W)) u_vid_match (
        .sample (vid_pix),
        .key    (key_q),
        .mask   (mask_q),
        .hit    (vid_hit)
    );

    always_comb begin
        take_vid = 1'b0;
        if (in_window) begin
            unique case (mode_q)
                KEY_ON_GFX_MATCH:    take_vid = gfx_hit;
                KEY_ON_VID_MISMATCH: take_vid = !vid_hit;
                default:             take_vid = 1'b0;
            endcase
        end
        sel_pix = take_vid ? vid_pix : gfx_pix;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            out_valid  <= 1'b0;
            out_window <= 1'b0;
            out_pix    <= '0;
        end else begin
            out_valid  <= in_valid;
            out_window <= in_window;
            out_pix    <= sel_pix;
        end
    end

    always_comb begin
        mode_rdata = mode_q;
    end

    AST_VALID_LATENCY: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> out_valid); // R8
    AST_WINDOW_LATENCY: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> out_window == $past(in_window)); // R8
    AST_OUTSIDE_GFX: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && !in_window) |=> out_pix == $past(gfx_pix)); // R6
    AST_SOURCE_LEGAL: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> (out_pix == $past(gfx_pix) || out_pix == $past(vid_pix))); // R4
endmodule

// File: tb/ckmix_overlay_mixer_bench.sv
module ckmix_overlay_mixer_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        in_valid = 1'b0;
    logic        in_window = 1'b0;
    logic [23:0] gfx_pix = '0;
    logic [23:0] vid_pix = '0;
    logic        key_we = 1'b0;
    logic        mask_we = 1'b0;
    logic        mode_we = 1'b0;
    logic [23:0] cfg_wdata = '0;
    logic [31:0] key_rdata;
    logic [31:0] mask_rdata;
    logic        mode_rdata;
    logic        out_valid;
    logic        out_window;
    logic [23:0] out_pix;

    int tests = 0;
    int fails = 0;
    bit done  = 1'b0;

    always #4 clk = ~clk;

    ckmix_overlay_mixer u_ckmix_overlay_mixer (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_window(in_window),
        .gfx_pix(gfx_pix), .vid_pix(vid_pix), .key_we(key_we), .mask_we(mask_we),
        .mode_we(mode_we), .cfg_wdata(cfg_wdata), .key_rdata(key_rdata),
        .mask_rdata(mask_rdata), .mode_rdata(mode_rdata), .out_valid(out_valid),
        .out_window(out_window), .out_pix(out_pix)
    );

    // {mode, key, mask, window, gfx, vid, expect_video}
    localparam int NV = 9;
    localparam logic [98:0] VEC [NV] = '{
        {1'b0, 24'h00FF00, 24'hFFFFFF, 1'b1, 24'h00FF00, 24'h123456, 1'b1}, // R4 exact match
        {1'b0, 24'h00FF00, 24'hFFFFFF, 1'b1, 24'h00FF01, 24'h123456, 1'b0}, // R4 miss
        {1'b0, 24'h00FF00, 24'hFFFF00, 1'b1, 24'h00FF7E, 24'h123456, 1'b1}, // R7 range
        {1'b0, 24'h00FF00, 24'hFFFFFF, 1'b0, 24'h00FF00, 24'h123456, 1'b0}, // R6
        {1'b1, 24'h101010, 24'hFFFFFF, 1'b1, 24'hABCDEF, 24'h101010, 1'b0}, // R5 match
        {1'b1, 24'h101010, 24'hFFFFFF, 1'b1, 24'hABCDEF, 24'h101011, 1'b1}, // R5 mismatch
        {1'b1, 24'h101010, 24'hF0F0F0, 1'b1, 24'hABCDEF, 24'h1A1B1C, 1'b0}, // R7 masked
        {1'b1, 24'h101010, 24'hFFFFFF, 1'b0, 24'hABCDEF, 24'h999999, 1'b0}, // R6
        {1'b0, 24'h0000FF, 24'h0000F0, 1'b1, 24'h1234F5, 24'h777777, 1'b1}  // R7 key masked
    };

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        tests++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic wr(input int which, input logic [23:0] d);
        @(negedge clk);
        cfg_wdata = d;
        key_we  = (which == 0);
        mask_we = (which == 1);
        mode_we = (which == 2);
        @(negedge clk);
        key_we = 1'b0; mask_we = 1'b0; mode_we = 1'b0;
    endtask

    task automatic pix(input logic win, input logic [23:0] g, input logic [23:0] v);
        @(negedge clk);
        in_valid = 1'b1; in_window = win; gfx_pix = g; vid_pix = v;
        @(negedge clk);
        in_valid = 1'b0;
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1 key", key_rdata, 32'h0);
        chk("R1 mask", mask_rdata, 32'h0);
        chk("R1 mode", {31'b0, mode_rdata}, 32'h0);
        chk("R1 valid", {31'b0, out_valid}, 32'h0);

        pix(1'b1, 24'hAAAAAA, 24'h555555);
        chk("R7 zero mask mode0", {8'h0, out_pix}, 32'h555555);
        wr(2, 24'h000001);
        pix(1'b1, 24'hAAAAAA, 24'h555555);
        chk("R7 zero mask mode1", {8'h0, out_pix}, 32'hAAAAAA);

        for (int i = 0; i < NV; i++) begin
            logic [98:0] v;
            v = VEC[i];
            wr(0, v[97:74]);
            wr(1, v[73:50]);
            wr(2, {23'b0, v[98]});
            pix(v[49], v[48:25], v[24:1]);
            chk($sformatf("R4/R5/R6 vec%0d pix", i), {8'h0, out_pix},
                {8'h0, (v[0] ? v[24:1] : v[48:25])});
            chk($sformatf("R8 vec%0d win", i), {31'b0, out_window}, {31'b0, v[49]});
            chk($sformatf("R8 vec%0d valid", i), {31'b0, out_valid}, 32'h1);
        end

        @(negedge clk);
        chk("R8 valid drops", {31'b0, out_valid}, 32'h0);

        wr(0, 24'hFFFFFF);
        chk("R2 key readback", key_rdata, 32'h00FFFFFF);
        wr(1, 24'hFFFFFF);
        chk("R3 mask readback", mask_rdata, 32'h00FFFFFF);

        // R9: key write coincides with a pixel
        wr(0, 24'h00FF00);
        wr(2, 24'h000000);
        @(negedge clk);
        cfg_wdata = 24'h000001; key_we = 1'b1;
        in_valid = 1'b1; in_window = 1'b1; gfx_pix = 24'h00FF00; vid_pix = 24'h5A5A5A;
        @(negedge clk);
        key_we = 1'b0;
        chk("R9 old key used", {8'h0, out_pix}, 32'h5A5A5A);
        @(negedge clk);
        in_valid = 1'b0;
        chk("R9 new key used", {8'h0, out_pix}, 32'h00FF00);

        done = 1'b1;
        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            tests++;
            fails++;
            $display("FAIL watchdog actual=timeout expected=completion");
            $display("  [TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end
endmodule